// File: doc/BRIEF.md
# Asynchronous ROM/SRAM Bank Read Sequencer

This block runs read cycles on one static memory bank that has no clock of its own. A host issues a read by pulsing a request line together with an address and a 15-bit timing word. The sequencer then walks the bus through a fixed order of phases. The address becomes valid first, then chip select falls, then output enable falls for the access interval. After that the strobes are released in the reverse order. Every phase length is taken from a small code in the timing word.

The timing codes are not linear. Most hold and setup phases use a 2-bit code. The main access time uses a 3-bit code. A page option returns up to sixteen consecutive words in one request. In that mode chip select and output enable stay low, the address steps by one for each beat, and each later beat uses its own shorter access time. Each returned word comes out with a one-cycle valid flag. A one-cycle done pulse marks the end of the whole request.

Top module: `async_bank_timer`

## Requirements
- R1: While reset is held and after it is released with no request, `mem_cs_n` and `mem_oe_n` are 1, while `mem_addr_vld`, `busy`, `done` and `rd_valid` are 0.
- R2: Chip select is low only while the address is valid, and output enable is low only while chip select is low. The sequence is: address valid, then chip select asserted, then output enable asserted, then output enable released, then chip select released, then address released.
- R3: Four phases use the 2-bit code 00=0, 01=1, 10=2, 11=4 clocks:
  - address setup before chip select, at bits [14:13];
  - chip-select setup before output enable, at [12:11];
  - chip-select hold after output enable, at [7:6];
  - address hold after chip select, at [5:4].
- R4: The access time is at bits [10:8]. Codes 0 to 7 give 1, 2, 3, 4, 6, 8, 10 and 14 clocks of output enable low for the first word.
- R5: Bits [1:0] select 1, 4, 8 or 16 words per request. Each word after the first keeps output enable low for the page time at bits [3:2], where codes 0 to 3 give 2, 3, 4 and 6 clocks. Output enable and chip select stay low across all words.
- R6: A phase whose code gives 0 clocks adds no cycle. With an all-zero timing word, a request takes one access cycle plus the done cycle.
- R7: Read data is captured on the last clock of each access or page interval and shown on `rd_data` with `rd_valid` high for one cycle after that. The address rises by one per word and wraps at the top of the address space.
- R8: `done` is high for exactly one cycle, right after the address hold phase. In that cycle all strobes are released, and `busy` is low on the next cycle.
- R9: A request is taken only when the sequencer is idle. The timing word and the address are latched when the request is taken. A request or changed inputs while busy have no effect on the running access and start no new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_rd | input | 1 | Read request, taken only when idle |
| req_addr | input | ADDR_W | Start address of the request |
| req_cfg | input | 15 | Bank timing word |
| busy | output | 1 | Sequencer is running a request |
| mem_addr | output | ADDR_W | Address to the bank |
| mem_addr_vld | output | 1 | Address phase is active |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_rdata | input | DATA_W | Data from the bank |
| rd_data | output | DATA_W | Captured read word |
| rd_valid | output | 1 | One-cycle flag for `rd_data` |
| done | output | 1 | One-cycle end-of-request pulse |

## Verification
The bench builds the block with its defaults: 16-bit address and 16-bit data. Because the two widths are equal, the bank model can return the address XOR a constant. Every captured word therefore shows which address was on the bus when it was sampled. A 4-word page that starts two below the top of the address space shows the wrap. The vector table covers each 2-bit code value, several access and page codes, and the 1-, 4-, 8- and 16-word page settings. One run also holds a competing request with a different timing word during a long access.

// File: rtl/async_bank_timer.sv
module async_bank_timer #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_rd,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [14:0]       req_cfg,
  output logic              busy,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_addr_vld,
  output logic              mem_cs_n,
  output logic              mem_oe_n,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              done
);

  typedef enum logic [2:0] {
    S_IDLE, S_ASU, S_CSU, S_ACC, S_PAGE, S_CSH, S_AH, S_DONE
  } st_t;

  st_t               state, after_st;
  logic [3:0]        cnt;
  logic [3:0]        beats_left;
  logic [14:0]       cfg_q;
  logic [ADDR_W-1:0] addr_q;

  function automatic logic [3:0] two_bit_len(input logic [1:0] c);
    case (c)
      2'd0:    return 4'd0;
      2'd1:    return 4'd1;
      2'd2:    return 4'd2;
      default: return 4'd4;
    endcase
  endfunction

  function automatic logic [3:0] acc_len(input logic [2:0] c);
    case (c)
      3'd0:    return 4'd1;
      3'd1:    return 4'd2;
      3'd2:    return 4'd3;
      3'd3:    return 4'd4;
      3'd4:    return 4'd6;
      3'd5:    return 4'd8;
      3'd6:    return 4'd10;
      default: return 4'd14;
    endcase
  endfunction

  function automatic logic [3:0] page_len(input logic [1:0] c);
    case (c)
      2'd0:    return 4'd2;
      2'd1:    return 4'd3;
      2'd2:    return 4'd4;
      default: return 4'd6;
    endcase
  endfunction

  function automatic logic [3:0] extra_beats(input logic [1:0] c);
    case (c)
      2'd0:    return 4'd0;
      2'd1:    return 4'd3;
      2'd2:    return 4'd7;
      default: return 4'd15;
    endcase
  endfunction

  function automatic logic [3:0] phase_len(input st_t s, input logic [14:0] c);
    case (s)
      S_ASU:   return two_bit_len(c[14:13]);
      S_CSU:   return two_bit_len(c[12:11]);
      S_ACC:   return acc_len(c[10:8]);
      S_PAGE:  return page_len(c[3:2]);
      S_CSH:   return two_bit_len(c[7:6]);
      S_AH:    return two_bit_len(c[5:4]);
      default: return 4'd0;
    endcase
  endfunction

  function automatic st_t first_live(input st_t from, input logic [14:0] c);
    st_t r;
    r = S_DONE;
    for (int i = 6; i >= 1; i--) begin
      if (i >= int'(from) && i != int'(S_PAGE) && phase_len(st_t'(i), c) != 4'd0)
        r = st_t'(i);
    end
    return r;
  endfunction

  always_comb begin
    case (state)
      S_ASU:          after_st = first_live(S_CSU, cfg_q);
      S_CSU:          after_st = first_live(S_ACC, cfg_q);
      S_ACC, S_PAGE:  after_st = (beats_left != 4'd0) ? S_PAGE : first_live(S_CSH, cfg_q);
      S_CSH:          after_st = first_live(S_AH, cfg_q);
      default:        after_st = S_DONE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      cnt        <= '0;
      beats_left <= '0;
      cfg_q      <= '0;
      addr_q     <= '0;
      rd_data    <= '0;
      rd_valid   <= 1'b0;
    end else begin
      rd_valid <= 1'b0;
      case (state)
        S_IDLE: begin
          if (req_rd) begin
            cfg_q      <= req_cfg;
            addr_q     <= req_addr;
            beats_left <= extra_beats(req_cfg[1:0]);
            state      <= first_live(S_ASU, req_cfg);
            cnt        <= phase_len(first_live(S_ASU, req_cfg), req_cfg) - 4'd1;
          end
        end
        S_DONE: state <= S_IDLE;
        default: begin
          if (cnt != 4'd0) begin
            cnt <= cnt - 4'd1;
          end else begin
            if (state == S_ACC || state == S_PAGE) begin
              rd_data  <= mem_rdata;
              rd_valid <= 1'b1;
            end
            if (after_st == S_PAGE) begin
              beats_left <= beats_left - 4'd1;
              addr_q     <= addr_q + 1'b1;
            end
            state <= after_st;
            cnt   <= (after_st == S_DONE) ? 4'd0 : phase_len(after_st, cfg_q) - 4'd1;
          end
        end
      endcase
    end
  end

  assign busy         = (state != S_IDLE);
  assign done         = (state == S_DONE);
  assign mem_addr     = addr_q;
  assign mem_addr_vld = (state inside {S_ASU, S_CSU, S_ACC, S_PAGE, S_CSH, S_AH});
  assign mem_cs_n     = !(state inside {S_CSU, S_ACC, S_PAGE, S_CSH});
  assign mem_oe_n     = !(state inside {S_ACC, S_PAGE});

  assert_cs_inside_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_cs_n |-> mem_addr_vld);

  assert_oe_inside_cs_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> !mem_cs_n);

  assert_addr_steady_under_cs_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_cs_n && $past(!mem_cs_n) && mem_oe_n) |-> $stable(mem_addr));

  assert_valid_after_oe_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(!mem_oe_n));

  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && !busy);

  assert_done_released_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (mem_cs_n && mem_oe_n && !mem_addr_vld));

  assert_start_needs_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(req_rd));

endmodule

// File: tb/test_async_bank_timer.sv
module test_async_bank_timer;

  localparam int ADDR_W = 16;
  localparam int DATA_W = 16;
  localparam logic [15:0] KEY = 16'h5A3C;
  localparam int NV = 11;

  localparam logic [14:0] V_CFG [NV] = '{15'h0000, 15'h7FFC, 15'h36AC, 15'h2B51, 15'h000F,
                                         15'h4436, 15'h0001, 15'h0500, 15'h0200, 15'h0100, 15'h0009};
  localparam logic [15:0] V_ADDR[NV] = '{16'h0100, 16'h1234, 16'h0F00, 16'h2000, 16'h4000,
                                         16'h8888, 16'hFFFE, 16'h0300, 16'h0400, 16'h0500, 16'h0600};
  localparam int V_ASU [NV] = '{0, 4, 1, 1, 0, 2, 0, 0, 0, 0, 0};
  localparam int V_CSU [NV] = '{0, 4, 2, 1, 0, 0, 0, 0, 0, 0, 0};
  localparam int V_OEL [NV] = '{1, 14, 10, 10, 91, 27, 7, 8, 3, 2, 13};
  localparam int V_CSH [NV] = '{0, 4, 2, 1, 0, 0, 0, 0, 0, 0, 0};
  localparam int V_AH  [NV] = '{0, 4, 2, 1, 0, 4, 0, 0, 0, 0, 0};
  localparam int V_BEAT[NV] = '{1, 1, 1, 4, 16, 8, 4, 1, 1, 1, 4};

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_rd = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [14:0]       req_cfg = '0;
  logic              busy, mem_addr_vld, mem_cs_n, mem_oe_n, rd_valid, done;
  logic [ADDR_W-1:0] mem_addr;
  logic [DATA_W-1:0] mem_rdata, rd_data;

  int checks = 0;
  int fails = 0;

  always #5 clk = ~clk;

  assign mem_rdata = mem_oe_n ? '0 : (mem_addr ^ KEY);

  async_bank_timer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_async_bank_timer (
    .clk(clk), .rst_n(rst_n), .req_rd(req_rd), .req_addr(req_addr), .req_cfg(req_cfg),
    .busy(busy), .mem_addr(mem_addr), .mem_addr_vld(mem_addr_vld), .mem_cs_n(mem_cs_n),
    .mem_oe_n(mem_oe_n), .mem_rdata(mem_rdata), .rd_data(rd_data), .rd_valid(rd_valid),
    .done(done)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic run_req(input logic [14:0] cfg, input logic [15:0] addr,
                         input int e_asu, input int e_csu, input int e_oel,
                         input int e_csh, input int e_ah, input int e_beat,
                         input bit noise);
    int n_asu = 0, n_csu = 0, n_oel = 0, n_csh = 0, n_ah = 0, n_beat = 0;
    int n_tot = 0, bad_data = 0, bad_order = 0;
    bit seen_cs = 0, seen_oe = 0, finished = 0;
    @(negedge clk);
    req_rd = 1'b1; req_cfg = cfg; req_addr = addr;
    @(posedge clk);
    @(negedge clk);
    req_rd = 1'b0;
    while (!finished && n_tot < 500) begin
      n_tot++;
      if (noise && n_tot == 3) begin
        req_rd = 1'b1; req_cfg = 15'h0000; req_addr = 16'hDEAD;
      end
      if (noise && n_tot == 4) req_rd = 1'b0;
      if (!mem_cs_n && !mem_addr_vld) bad_order++;
      if (!mem_oe_n && mem_cs_n) bad_order++;
      if (!mem_cs_n) seen_cs = 1;
      if (!mem_oe_n) seen_oe = 1;
      if (mem_addr_vld && mem_cs_n && !seen_cs) n_asu++;
      if (!mem_cs_n && mem_oe_n && !seen_oe) n_csu++;
      if (!mem_oe_n) n_oel++;
      if (!mem_cs_n && mem_oe_n && seen_oe) n_csh++;
      if (mem_addr_vld && mem_cs_n && seen_cs) n_ah++;
      if (rd_valid) begin
        if (rd_data != ((addr + 16'(n_beat)) ^ KEY)) bad_data++;
        n_beat++;
      end
      if (done) finished = 1;
      else @(negedge clk);
    end
    check("R2 strobe order violations", bad_order, 0);
    check("R3 address setup clocks", n_asu, e_asu);
    check("R3 cs setup clocks", n_csu, e_csu);
    check("R4/R5 oe low clocks", n_oel, e_oel);
    check("R3 cs hold clocks", n_csh, e_csh);
    check("R3 address hold clocks", n_ah, e_ah);
    check("R5 words returned", n_beat, e_beat);
    check("R7 data/address per word", bad_data, 0);
    check("R6/R8 cycles to done", n_tot, e_asu + e_csu + e_oel + e_csh + e_ah + 1);
    @(negedge clk);
    check("R8 done single and idle after",
          int'({busy, done, mem_cs_n, mem_oe_n, mem_addr_vld}), int'(5'b00110));
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 outputs in reset",
          int'({busy, done, rd_valid, mem_cs_n, mem_oe_n, mem_addr_vld}), int'(6'b000110));
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 outputs idle after reset",
          int'({busy, done, rd_valid, mem_cs_n, mem_oe_n, mem_addr_vld}), int'(6'b000110));

    for (int v = 0; v < NV; v++)
      run_req(V_CFG[v], V_ADDR[v], V_ASU[v], V_CSU[v], V_OEL[v], V_CSH[v], V_AH[v], V_BEAT[v], 1'b0);

    // R9: competing request with a different word during a long access
    run_req(15'h7FFC, 16'h3000, 4, 4, 14, 4, 4, 1, 1'b1);
    repeat (3) @(negedge clk);
    check("R9 no access started by ignored request", int'({busy, mem_addr_vld}), 0);

    // R6: back-to-back all-zero requests
    run_req(15'h0000, 16'h7777, 0, 0, 1, 0, 0, 1, 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule